// File: doc/BRIEF.md
# One-Wire Bit-Slot Timing Engine

This block produces the individual time slots of a one-wire bus master on a single open-drain line. A slot is started by a one-cycle start strobe together with a command. The command is either a bus reset with presence detection, or a "touch" that carries one bit. A touch with bit 1 opens a short low pulse and samples what a device leaves on the line, so a single operation both writes a 1 and reads a bit. A touch with bit 0 holds the line low long enough to write a 0.

All slot durations are counted in microsecond ticks. A clock divider makes these ticks, and it restarts on every accepted start, so each phase boundary falls a whole number of ticks after the start edge. An integer stretch factor lengthens every duration by the same amount, for slow or heavily loaded buses. The line input passes through a two-flop synchroniser before it is sampled. A one-clock done pulse marks the end of a slot. The sampled bit and the presence flag stay valid until the next slot is accepted. The controller above handles bytes, ROM commands and CRC, and it issues one slot at a time.

Top module: `owire_slot_engine`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) drive_low, done, rx_bit and presence are all 0.
- R2: A touch (cmd_reset = 0) with tx_bit = 1 pulls the line low for 6 us, then releases it, and the slot lasts 70 us in total. This is both the write-1 profile (6 us low, 64 us released) and the read profile.
- R3: In a touch with tx_bit = 1, rx_bit takes the line level sampled 9 us after release (15 us after the slot starts). The sampled value is the level at the output of a two-flop synchroniser, so it reflects the line two clocks before the sampling edge.
- R4: A touch with tx_bit = 0 pulls the line low for 60 us, releases it for 10 us of recovery, and sets rx_bit to 0 whatever the line does.
- R5: A reset (cmd_reset = 1) pulls the line low for 500 us and samples the line 70 us after release. It then waits RECOVER_US more (never less than 430 us), so by default the slot is 1000 us long.
- R6: After a reset, presence is 1 if the line was low at the sample point and 0 if it was high. A reset leaves rx_bit unchanged, and a touch leaves presence unchanged.
- R7: Every duration above equals its microsecond value × STRETCH × CLK_PER_US clock cycles, measured from the clock edge that accepts start.
- R8: done is high for exactly one clock at the end of each slot. rx_bit and presence keep their values from then until the next accepted start.
- R9: start, cmd_reset and tx_bit are ignored while a slot is in progress. A strobe during a slot changes neither its line profile nor its end time, and it does not begin a new slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a slot when idle |
| cmd_reset | input | 1 | 1 = reset/presence slot, 0 = touch slot |
| tx_bit | input | 1 | Bit for a touch slot (1 = read/write-1, 0 = write-0) |
| line_in | input | 1 | Level seen on the bus (asynchronous) |
| drive_low | output | 1 | 1 pulls the open-drain bus low, 0 releases it |
| rx_bit | output | 1 | Bit sampled by the last touch slot |
| presence | output | 1 | A device answered the last reset |
| done | output | 1 | One-clock pulse at slot end |

## Verification
The assertions check on every cycle that done never lasts two clocks, that the line is released whenever the engine is idle, that the phase counter never reaches zero during a slot, that every release of the line coincides with a microsecond tick, and that the tick never fires on two clocks in a row. Whether the bus is low for the right number of cycles, whether the sample point falls at the right place, and whether a strobe in the middle of a slot leaves it alone can only be shown by the bench. The bench runs every slot type against devices that answer and devices that stay silent, and it uses a device pulse so narrow that a sample taken a few clocks too early or too late would miss it.

// File: rtl/owire_pkg.sv
// Shared slot timings (in microseconds) and the engine phase type.
// Assumes every duration is nonzero so each phase lasts at least one tick.
package owire_pkg;
    localparam int unsigned RD_LOW_US          = 6;
    localparam int unsigned RD_SAMPLE_US       = 9;
    localparam int unsigned RD_TAIL_US         = 55;
    localparam int unsigned W0_LOW_US          = 60;
    localparam int unsigned W0_RECOVER_US      = 10;
    localparam int unsigned RST_LOW_US         = 500;
    localparam int unsigned RST_SAMPLE_US      = 70;
    localparam int unsigned RST_MIN_RECOVER_US = 430;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_PRE  = 2'd2,
        PH_POST = 2'd3
    } phase_e;
endpackage

// File: rtl/owire_tick_gen.sv
// Microsecond tick divider. Emits tick on one clock out of every CLK_PER_US.
// A restart pulse realigns it, so the first tick after a start comes
// exactly CLK_PER_US clocks later.
module owire_tick_gen #(
    parameter int unsigned CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    // Divider counter: wraps at LAST, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);

    generate
        if (CLK_PER_US > 1) begin : g_tick_chk
            // R7: ticks are isolated single-clock events when the divider is real
            a_r7_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !restart) |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/owire_sync.sv
// Two-flop synchroniser for the asynchronous bus level.
// Resets to 1, the level of a released, pulled-up bus.
module owire_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic stab_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            stab_q <= 1'b1;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/owire_slot_seq.sv
// Slot sequencer. Runs three phases: line low, released until the sample
// point (or the end of recovery for write-0), and released tail. Each phase
// is loaded into a single down-counter of ticks. Assumes tick comes from a
// divider that this block restarts on every accepted start.
module owire_slot_seq
    import owire_pkg::*;
#(
    parameter int unsigned STRETCH    = 1,
    parameter int unsigned RECOVER_US = 430
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmd_reset,
    input  logic tx_bit,
    input  logic tick,
    input  logic line_s,
    output logic restart,
    output logic drive_low,
    output logic rx_bit,
    output logic presence,
    output logic done
);
    localparam int unsigned REC_EFF  = (RECOVER_US < RST_MIN_RECOVER_US) ?
                                       RST_MIN_RECOVER_US : RECOVER_US;
    localparam int unsigned MAX_US   = (REC_EFF > RST_LOW_US) ? REC_EFF : RST_LOW_US;
    localparam int unsigned MAX_TICK = MAX_US * STRETCH;
    localparam int unsigned CW       = $clog2(MAX_TICK + 1);

    localparam logic [CW-1:0] T_RD_LOW  = CW'(RD_LOW_US * STRETCH);
    localparam logic [CW-1:0] T_RD_SMP  = CW'(RD_SAMPLE_US * STRETCH);
    localparam logic [CW-1:0] T_RD_TAIL = CW'(RD_TAIL_US * STRETCH);
    localparam logic [CW-1:0] T_W0_LOW  = CW'(W0_LOW_US * STRETCH);
    localparam logic [CW-1:0] T_W0_REC  = CW'(W0_RECOVER_US * STRETCH);
    localparam logic [CW-1:0] T_RS_LOW  = CW'(RST_LOW_US * STRETCH);
    localparam logic [CW-1:0] T_RS_SMP  = CW'(RST_SAMPLE_US * STRETCH);
    localparam logic [CW-1:0] T_RS_REC  = CW'(REC_EFF * STRETCH);
    localparam logic [CW-1:0] ONE       = CW'(1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic          op_reset_q;
    logic          op_read_q;
    logic          accept;
    logic          phase_end;

    assign accept    = start && (ph_q == PH_IDLE);
    assign restart   = accept;
    assign phase_end = tick && (cnt_q == ONE);

    // Phase sequencing, duration loading, sampling and done generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            cnt_q      <= '0;
            op_reset_q <= 1'b0;
            op_read_q  <= 1'b0;
            drive_low  <= 1'b0;
            rx_bit     <= 1'b0;
            presence   <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        op_reset_q <= cmd_reset;
                        op_read_q  <= !cmd_reset && tx_bit;
                        ph_q       <= PH_LOW;
                        drive_low  <= 1'b1;
                        cnt_q      <= cmd_reset ? T_RS_LOW : (tx_bit ? T_RD_LOW : T_W0_LOW);
                    end
                end
                PH_LOW: begin
                    if (phase_end) begin
                        ph_q      <= PH_PRE;
                        drive_low <= 1'b0;
                        cnt_q     <= op_reset_q ? T_RS_SMP : (op_read_q ? T_RD_SMP : T_W0_REC);
                    end else if (tick) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PRE: begin
                    if (phase_end) begin
                        if (op_reset_q || op_read_q) begin
                            ph_q  <= PH_POST;
                            cnt_q <= op_reset_q ? T_RS_REC : T_RD_TAIL;
                            if (op_reset_q) begin
                                presence <= !line_s;
                            end else begin
                                rx_bit <= line_s;
                            end
                        end else begin
                            ph_q   <= PH_IDLE;
                            cnt_q  <= '0;
                            rx_bit <= 1'b0;
                            done   <= 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_POST: begin
                    if (phase_end) begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                        done  <= 1'b1;
                    end else if (tick) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R8: done never lasts longer than one clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done only ends a slot that was running
    a_r8_done_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ph_q) != PH_IDLE));
    // R1: an idle engine never holds the bus low
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE) |-> !drive_low);
    // R9: a running slot always has time left
    a_r9_counter_live: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_IDLE) |-> (cnt_q != '0));
    // R7: the line is released only on a microsecond tick
    a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low) |-> $past(tick));
endmodule

// File: rtl/owire_slot_engine.sv
// One-wire bit-slot engine top. Connects the restartable microsecond
// divider, the line synchroniser and the slot sequencer. Assumes one slot
// at a time; commands presented while busy are dropped.
module owire_slot_engine #(
    parameter int unsigned CLK_PER_US = 50,
    parameter int unsigned STRETCH    = 1,
    parameter int unsigned RECOVER_US = 430
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmd_reset,
    input  logic tx_bit,
    input  logic line_in,
    output logic drive_low,
    output logic rx_bit,
    output logic presence,
    output logic done
);
    logic tick;
    logic restart;
    logic line_s;

    owire_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    owire_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_s)
    );

    owire_slot_seq #(.STRETCH(STRETCH), .RECOVER_US(RECOVER_US)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_reset (cmd_reset),
        .tx_bit    (tx_bit),
        .tick      (tick),
        .line_s    (line_s),
        .restart   (restart),
        .drive_low (drive_low),
        .rx_bit    (rx_bit),
        .presence  (presence),
        .done      (done)
    );
endmodule

// File: tb/owire_slot_engine_test.sv
// Self-checking bench: sweeps every slot kind against answering and silent
// devices, plus mid-slot strobes, on a small divider/stretch configuration.
module owire_slot_engine_test;
    localparam int P   = 2;
    localparam int S   = 2;
    localparam int REC = 430;
    localparam int U   = P * S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_reset = 1'b0;
    logic tx_bit = 1'b0;
    logic dev_low = 1'b0;
    logic line_in;
    logic drive_low, rx_bit, presence, done;

    int vecs = 0;
    int errs = 0;
    int cycles = 0;
    bit exp_rx = 1'b0;
    bit exp_pres = 1'b0;

    always #10 clk = ~clk;

    assign line_in = !(drive_low || dev_low);

    owire_slot_engine #(.CLK_PER_US(P), .STRETCH(S), .RECOVER_US(REC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_reset(cmd_reset),
        .tx_bit(tx_bit), .line_in(line_in), .drive_low(drive_low),
        .rx_bit(rx_bit), .presence(presence), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one slot; poke_at > 0 strobes a conflicting command at that index.
    task automatic run_slot(input bit rs, input bit b, input bit dv, input int poke_at,
                            output int low_cnt, output int done_idx, output int done_cnt,
                            output int first_low);
        int sidx;
        int total;
        sidx = rs ? U * (500 + 70) : (b ? U * (6 + 9) : U * (60 + 5));
        total = rs ? U * (500 + 70 + REC) : U * 70;
        low_cnt = 0; done_idx = 0; done_cnt = 0; first_low = 0;
        @(negedge clk);
        start = 1'b1; cmd_reset = rs; tx_bit = b;
        for (int i = 1; i <= total + 6; i++) begin
            @(negedge clk);
            if (drive_low) low_cnt++;
            if (i == 1) first_low = drive_low;
            if (done) begin
                done_cnt++;
                if (done_idx == 0) done_idx = i;
            end
            dev_low = dv && (i >= sidx - 3) && (i <= sidx + 1);
            if (i == poke_at) begin
                start = 1'b1; cmd_reset = !rs; tx_bit = !b;
            end else begin
                start = 1'b0;
            end
        end
        dev_low = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                vecs++; errs++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
                $finish;
            end
        end
    end

    initial begin : stim
        int lc, di, dc, fl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drive_low", drive_low, 0);
        chk("R1 done", done, 0);
        chk("R1 rx_bit", rx_bit, 0);
        chk("R1 presence", presence, 0);

        for (int rep = 0; rep < 2; rep++) begin
            for (int kind = 0; kind < 3; kind++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    bit rs;
                    bit b;
                    rs = (kind == 2);
                    b  = (kind == 0);
                    run_slot(rs, b, dv[0], 0, lc, di, dc, fl);
                    chk("R7 low at first cycle", fl, 1);
                    chk("R8 done width", dc, 1);
                    if (kind == 0) begin
                        chk("R2 read low cycles", lc, U * 6);
                        chk("R2 read done index", di, U * 70 + 1);
                        exp_rx = !dv[0];
                        chk("R3 read sample", rx_bit, exp_rx);
                    end else if (kind == 1) begin
                        chk("R4 write0 low cycles", lc, U * 60);
                        chk("R4 write0 done index", di, U * 70 + 1);
                        exp_rx = 1'b0;
                        chk("R4 write0 rx_bit", rx_bit, 0);
                    end else begin
                        chk("R5 reset low cycles", lc, U * 500);
                        chk("R5 reset done index", di, U * (500 + 70 + REC) + 1);
                        exp_pres = dv[0];
                        chk("R6 presence", presence, exp_pres);
                        chk("R6 reset keeps rx_bit", rx_bit, exp_rx);
                    end
                    chk("R6 presence held", presence, exp_pres);
                    repeat (20) @(negedge clk);
                    chk("R8 rx_bit stable", rx_bit, exp_rx);
                    chk("R8 presence stable", presence, exp_pres);
                    chk("R8 idle released", drive_low, 0);
                end
            end
        end

        // R9: a reset strobe during a read slot is dropped
        run_slot(1'b0, 1'b1, 1'b1, 10, lc, di, dc, fl);
        chk("R9 read low unchanged", lc, U * 6);
        chk("R9 read end unchanged", di, U * 70 + 1);
        chk("R9 single done", dc, 1);
        chk("R9 read result", rx_bit, 0);
        exp_rx = 1'b0;

        // R9: a touch strobe during a reset slot is dropped
        run_slot(1'b1, 1'b0, 1'b0, U * 520, lc, di, dc, fl);
        chk("R9 reset low unchanged", lc, U * 500);
        chk("R9 reset end unchanged", di, U * (500 + 70 + REC) + 1);
        chk("R9 reset single done", dc, 1);
        chk("R9 presence result", presence, 0);

        // R3: narrow pulse on a write-1 touch sampled correctly after a write-0
        run_slot(1'b0, 1'b0, 1'b1, 0, lc, di, dc, fl);
        chk("R4 write0 ignores line", rx_bit, 0);
        run_slot(1'b0, 1'b1, 1'b1, 0, lc, di, dc, fl);
        chk("R3 read low level", rx_bit, 0);
        run_slot(1'b0, 1'b1, 1'b0, 0, lc, di, dc, fl);
        chk("R3 read high level", rx_bit, 1);

        repeat (10) @(negedge clk);
        chk("R8 no stray done", done, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule